// File: doc/BRIEF.md
# Serial Peripheral Master with Paced Byte Queues

This block is a register-mapped serial peripheral master. Software programs a clock divider, picks one of three chip-select lines with its active level, chooses clock idle level and sampling phase, and then raises the run bit. Bytes written to the data window enter a 16-entry transmit queue. Each byte is shifted out MSB first on the data-out pin while the data-in pin is sampled into a 16-entry receive queue, which software or a DMA engine drains through the same window.

For DMA use, two request outputs pace the queues. A byte count can be loaded so that the controller drops the run bit by itself, releases chip select and flags completion once that many bytes have been exchanged. One interrupt output combines the completion flag and a receive-level flag, each under its own enable.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset the control/status word (word 0) reads 0x0004_0000 (only the transmit-space flag at bit 18), all chip-select pins sit at their inactive level (high), the clock pin is low, and both DMA requests and the interrupt are low.
- R2: Word 0 holds line select [1:0], phase [2], clock idle level [3], global select level [6], run [7], DMA enable [8], completion interrupt enable [9], receive interrupt enable [10], automatic release [11] and per-line select level [23:21], all readable back; word 2 holds the 16-bit divider and word 3 the 16-bit byte count.
- R3: The clock pin toggles every max(D/2, 1) core cycles, rounding D/2 down, where D is the divider with 0 standing for 65536.
- R4: The clock rests at the idle level, each byte makes 16 toggles, data leaves MSB first; with phase 0 data-in is sampled on the edge leaving the idle level and data-out moves on the edge returning to it, with phase 1 the other way round; received bytes are read from word 1 in arrival order.
- R5: While run is set, line n equal to the select field (0..2) drives its active level, which is high if bit 21+n or bit 6 is set and low otherwise; every other line, and all lines when the field is 3 or run is clear, drives the opposite level.
- R6: Status bits: receive non-empty [17], transmit not full [18], receive holds 12 or more [19], receive full [20]; no byte exchange starts while the receive queue is full.
- R7: Writing word 0 with bit 4 set empties the transmit queue, with bit 5 set empties the receive queue; a read of word 1 with an empty receive queue returns 0.
- R8: With automatic release, the byte count is captured when run goes from 0 to 1; after that many bytes run clears, chip select is released and the done bit [16] sets; any later word-0 write clears done.
- R9: Without automatic release, done reads 1 while run is set, the transmit queue is empty and no byte is in flight, and chip select stays driven until software clears run.
- R10: The transmit request is high when DMA and run are enabled, the transmit queue has room and, under automatic release, fewer bytes than the count have been written; the receive request is high when DMA is enabled and the receive queue is non-empty.
- R11: The interrupt equals (done and bit 9) or (receive-12-or-more flag and bit 10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive queue on word 1) |
| reg_addr | input | 2 | Word index: 0 control/status, 1 data, 2 divider, 3 count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select lines |
| dma_tx_req | output | 1 | Transmit queue wants data |
| dma_rx_req | output | 1 | Receive queue holds data |
| irq | output | 1 | Interrupt |

## Verification
Register reads are combinational and a write acts at the next rising edge, so the bench drives on the falling edge and reads the new state one falling edge later; the clock pin settles to a new idle level one cycle after that. A queued byte loads one cycle after it is written, its first clock toggle follows a half period later, its received value lands in the queue one cycle after the sixteenth toggle, and automatic release follows one cycle after that. Because these serial latencies scale with the divider, the bench polls the status bits for completion with bounded loops, while pin levels, request lines and the interrupt are sampled at the falling edge right after the write that should move them; the bit stream itself is rebuilt by a pin monitor and compared to the bytes sent.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int REG_CTL  = 0;
  localparam int REG_DATA = 1;
  localparam int REG_DIV  = 2;
  localparam int REG_CNT  = 3;

  localparam int B_CPHA  = 2;
  localparam int B_CPOL  = 3;
  localparam int B_TXCLR = 4;
  localparam int B_RXCLR = 5;
  localparam int B_CSPOL = 6;
  localparam int B_RUN   = 7;
  localparam int B_DMA   = 8;
  localparam int B_IEDN  = 9;
  localparam int B_IERX  = 10;
  localparam int B_AUTO  = 11;
  localparam int B_DONE  = 16;
  localparam int B_RXNE  = 17;
  localparam int B_TXSP  = 18;
  localparam int B_RXLVL = 19;
  localparam int B_RXFUL = 20;
  localparam int B_LPOL  = 21;

  // core cycles per clock-pin half period
  function automatic logic [16:0] half_cycles(input logic [15:0] div);
    logic [16:0] eff;
    logic [16:0] h;
    eff = (div == 16'd0) ? 17'h10000 : {1'b0, div};
    h = eff >> 1;
    if (h == 17'd0) h = 17'd1;
    return h;
  endfunction
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= din;
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push && !clr |-> !full);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !clr |-> !empty);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int BITS  = 8,
  localparam int EDGES = 2 * BITS,
  localparam int EW    = $clog2(EDGES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  logic [16:0]     half,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            busy,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte
);
  logic [BITS-1:0] sh;
  logic [16:0]     cnt;
  logic [EW-1:0]   edge_n;
  logic [EW-1:0]   nxt;
  logic            tick;

  assign nxt  = edge_n + 1'b1;
  assign tick = (cnt == half - 17'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk <= 1'b0; mosi <= 1'b0; sh <= '0;
      rx_byte <= '0; cnt <= '0; edge_n <= '0; byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!run || !busy) begin
        sclk <= cpol;
        cnt <= '0;
        edge_n <= '0;
        if (run && start) begin
          busy <= 1'b1;
          sh   <= tx_byte;
          mosi <= tx_byte[BITS-1];
        end else begin
          busy <= 1'b0;
        end
      end else if (tick) begin
        cnt    <= '0;
        sclk   <= ~sclk;
        edge_n <= nxt;
        if (nxt[0] != cpha) begin
          rx_byte <= {rx_byte[BITS-2:0], miso};
        end else if (nxt != EW'(1) && nxt != EW'(EDGES)) begin
          sh   <= {sh[BITS-2:0], 1'b0};
          mosi <= sh[BITS-2];
        end
        if (nxt == EW'(EDGES)) begin
          busy <= 1'b0;
          byte_done <= 1'b1;
        end
      end else begin
        cnt <= cnt + 17'd1;
      end
    end
  end

  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) && $stable(cpol) |-> sclk == cpol);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !busy);
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spi_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CS_LINES   = 3,
  parameter int BITS       = 8,
  localparam int CW        = $clog2(FIFO_DEPTH) + 1,
  localparam int RX_LVL    = (FIFO_DEPTH * 3) / 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [1:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                spi_sclk,
  output logic                spi_mosi,
  input  logic                spi_miso,
  output logic [CS_LINES-1:0] spi_cs,
  output logic                dma_tx_req,
  output logic                dma_rx_req,
  output logic                irq
);
  // control state
  logic [1:0]          cs_sel;
  logic                cpha, cpol, cs_pol, run, dma_en, ie_done, ie_rx, auto_rel;
  logic [CS_LINES-1:0] line_pol;
  logic [15:0]         div_q, cnt_q, xfer_left, push_left;
  logic                done_q;

  // queue and engine wires
  logic            tx_push, tx_pop, tx_full, tx_empty, tx_clr;
  logic            rx_push, rx_pop, rx_full, rx_empty, rx_clr;
  logic [BITS-1:0] tx_head, rx_head, eng_rx;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            eng_busy, eng_start, byte_done;
  logic            wr_ctl, wr_data, wr_div, wr_cnt, rd_data;
  logic            rx_lvl, done_stat, auto_finish;
  logic [CS_LINES-1:0] cs_on;

  assign wr_ctl  = reg_wr && reg_addr == 2'(REG_CTL);
  assign wr_data = reg_wr && reg_addr == 2'(REG_DATA);
  assign wr_div  = reg_wr && reg_addr == 2'(REG_DIV);
  assign wr_cnt  = reg_wr && reg_addr == 2'(REG_CNT);
  assign rd_data = reg_rd && reg_addr == 2'(REG_DATA);

  assign tx_clr  = wr_ctl && reg_wdata[B_TXCLR];
  assign rx_clr  = wr_ctl && reg_wdata[B_RXCLR];
  assign tx_push = wr_data && !tx_full;
  assign rx_pop  = rd_data && !rx_empty;
  assign rx_push = byte_done && !rx_full;

  assign eng_start = run && !tx_empty && !eng_busy && !byte_done && !rx_full &&
                     (!auto_rel || xfer_left != 16'd0);
  assign tx_pop = eng_start;

  assign auto_finish = run && auto_rel && xfer_left == 16'd0 && !eng_busy && !byte_done;
  assign rx_lvl    = rx_cnt >= CW'(RX_LVL);
  assign done_stat = done_q || (run && !auto_rel && tx_empty && !eng_busy && !byte_done);

  spi_fifo #(.W(BITS), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(reg_wdata[BITS-1:0]),
    .pop(tx_pop), .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_fifo #(.W(BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .din(eng_rx),
    .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spi_shifter #(.BITS(BITS)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .start(eng_start), .tx_byte(tx_head),
    .half(half_cycles(div_q)), .cpol(cpol), .cpha(cpha), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .busy(eng_busy), .byte_done(byte_done),
    .rx_byte(eng_rx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sel <= '0; cpha <= 1'b0; cpol <= 1'b0; cs_pol <= 1'b0; run <= 1'b0;
      dma_en <= 1'b0; ie_done <= 1'b0; ie_rx <= 1'b0; auto_rel <= 1'b0;
      line_pol <= '0; div_q <= '0; cnt_q <= '0; xfer_left <= '0;
      push_left <= '0; done_q <= 1'b0;
    end else begin
      if (byte_done && run && auto_rel && xfer_left != 16'd0)
        xfer_left <= xfer_left - 16'd1;
      if (tx_push && run && auto_rel && push_left != 16'd0)
        push_left <= push_left - 16'd1;
      if (auto_finish) begin
        run    <= 1'b0;
        done_q <= 1'b1;
      end
      if (wr_div) div_q <= reg_wdata[15:0];
      if (wr_cnt) cnt_q <= reg_wdata[15:0];
      if (wr_ctl) begin
        cs_sel   <= reg_wdata[1:0];
        cpha     <= reg_wdata[B_CPHA];
        cpol     <= reg_wdata[B_CPOL];
        cs_pol   <= reg_wdata[B_CSPOL];
        run      <= reg_wdata[B_RUN];
        dma_en   <= reg_wdata[B_DMA];
        ie_done  <= reg_wdata[B_IEDN];
        ie_rx    <= reg_wdata[B_IERX];
        auto_rel <= reg_wdata[B_AUTO];
        line_pol <= reg_wdata[B_LPOL +: CS_LINES];
        done_q   <= 1'b0;
        if (reg_wdata[B_RUN] && !run) begin
          xfer_left <= cnt_q;
          push_left <= cnt_q;
        end
      end
    end
  end

  // chip-select lines, one per generate slice
  for (genvar i = 0; i < CS_LINES; i++) begin : g_cs
    logic act_lvl;
    assign act_lvl   = line_pol[i] | cs_pol;
    assign cs_on[i]  = run && cs_sel == 2'(i);
    assign spi_cs[i] = cs_on[i] ? act_lvl : ~act_lvl;
  end

  assign dma_tx_req = dma_en && run && !tx_full && (!auto_rel || push_left != 16'd0);
  assign dma_rx_req = dma_en && !rx_empty;
  assign irq = (ie_done && done_stat) || (ie_rx && rx_lvl);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'(REG_CTL): begin
        reg_rdata[1:0]    = cs_sel;
        reg_rdata[B_CPHA] = cpha;
        reg_rdata[B_CPOL] = cpol;
        reg_rdata[B_CSPOL] = cs_pol;
        reg_rdata[B_RUN]  = run;
        reg_rdata[B_DMA]  = dma_en;
        reg_rdata[B_IEDN] = ie_done;
        reg_rdata[B_IERX] = ie_rx;
        reg_rdata[B_AUTO] = auto_rel;
        reg_rdata[B_DONE] = done_stat;
        reg_rdata[B_RXNE] = !rx_empty;
        reg_rdata[B_TXSP] = !tx_full;
        reg_rdata[B_RXLVL] = rx_lvl;
        reg_rdata[B_RXFUL] = rx_full;
        reg_rdata[B_LPOL +: CS_LINES] = line_pol;
      end
      2'(REG_DATA): reg_rdata[BITS-1:0] = rx_empty ? '0 : rx_head;
      2'(REG_DIV):  reg_rdata[15:0] = div_q;
      default:      reg_rdata[15:0] = cnt_q;
    endcase
  end

  a_r8_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run);
  a_r5_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_on));
  a_r10_tx_req_room: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> !tx_full && run);
  a_r6_start_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !rx_full);
endmodule

// File: tb/sim_spi_master_ctl.sv
`timescale 1ns/1ps
module sim_spi_master_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [2:0]  spi_cs;
  logic        dma_tx_req, dma_rx_req, irq;
  logic        inv_b = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;
  assign spi_miso = spi_mosi ^ inv_b;

  spi_master_ctl u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq(irq));

  // pin monitor: rebuilds transmitted bytes from the bench's own view of the mode
  logic cpol_b = 1'b0, cpha_b = 1'b0, mon_clr = 1'b0, prev_s = 1'b0;
  int   toggles = 0, nbits = 0, nbytes = 0;
  logic [7:0] acc = '0;
  logic [7:0] mon_b [32];

  always @(negedge clk) begin
    if (mon_clr) begin
      toggles = 0; nbits = 0; nbytes = 0; prev_s = spi_sclk;
    end else if (spi_sclk !== prev_s) begin
      toggles++;
      if ((prev_s == cpol_b) != cpha_b) begin
        acc = {acc[6:0], spi_mosi};
        nbits++;
        if (nbits == 8) begin
          if (nbytes < 32) mon_b[nbytes] = acc;
          nbytes++;
          nbits = 0;
        end
      end
      prev_s = spi_sclk;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all) got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic int exp_half(input int d);
    int e;
    e = (d == 0) ? 65536 : d;
    return (e / 2 < 1) ? 1 : e / 2;
  endfunction

  function automatic logic [31:0] mkctl(input int sel, input bit ph, input bit pl,
      input bit gp, input bit rn, input bit dm, input bit idn, input bit irx,
      input bit au, input logic [2:0] lp);
    logic [31:0] v;
    v = '0;
    v[1:0] = sel[1:0]; v[2] = ph; v[3] = pl; v[6] = gp; v[7] = rn;
    v[8] = dm; v[9] = idn; v[10] = irx; v[11] = au; v[23:21] = lp;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a[1:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a[1:0];
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic mclear();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic wait_stat(input int b, input int lim);
    logic [31:0] s;
    for (int i = 0; i < lim; i++) begin
      rd(0, s);
      if (s[b]) return;
    end
  endtask

  logic [31:0] v;
  logic [7:0]  sent [20];
  int bad, n;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mclear();

    // R1 reset state
    rd(0, v);
    chk("R1 status", v, 32'h0004_0000);
    chk("R1 pins", {spi_cs, spi_sclk, dma_tx_req, dma_rx_req, irq}, {3'b111, 4'b0000});

    // R2 register map read-back
    wr(2, 32'h0000_00AB); rd(2, v); chk("R2 divider", v, 32'h0000_00AB);
    wr(3, 32'h0000_1234); rd(3, v); chk("R2 count", v, 32'h0000_1234);
    wr(0, mkctl(2, 1, 1, 1, 0, 1, 1, 1, 1, 3'b101));
    rd(0, v);
    chk("R2 control", v, mkctl(2, 1, 1, 1, 0, 1, 1, 1, 1, 3'b101) | 32'h0004_0000);
    wr(0, 32'h30);

    // R3 half-period for several dividers
    foreach (sent[i]) sent[i] = 8'h00;
    for (int k = 0; k < 4; k++) begin
      int d;
      logic s;
      d = (k == 0) ? 6 : (k == 1) ? 7 : (k == 2) ? 1 : 0;
      wr(2, d);
      wr(0, mkctl(3, 0, 0, 0, 1, 0, 0, 0, 0, 3'b000));
      wr(1, 32'hA5);
      s = spi_sclk;
      for (int i = 0; i < 70000 && spi_sclk == s; i++) @(negedge clk);
      s = spi_sclk; n = 0;
      for (int i = 0; i < 70000 && spi_sclk == s; i++) begin @(negedge clk); n++; end
      chk("R3 half period", n, exp_half(d));
      wr(0, 32'h30);
    end

    // R4 four modes, loopback with random inversion, monitor rebuilds bytes
    wr(2, 4);
    for (int m = 0; m < 4; m++) begin
      cpol_b = m[1]; cpha_b = m[0];
      inv_b = $urandom_range(1, 0);
      wr(0, mkctl(0, cpha_b, cpol_b, 0, 0, 0, 0, 0, 0, 3'b000) | 32'h30);
      @(negedge clk);
      chk("R4 idle level", spi_sclk, cpol_b);
      mclear();
      wr(0, mkctl(0, cpha_b, cpol_b, 0, 1, 0, 0, 0, 0, 3'b000));
      for (int i = 0; i < 4; i++) begin
        sent[i] = 8'($urandom);
        wr(1, sent[i]);
      end
      wait_stat(16, 400);
      rd(0, v);
      chk("R9 done while run", {v[16], v[7]}, 2'b11);
      chk("R9 select held", spi_cs, 3'b110);
      chk("R4 toggle count", toggles, 64);
      bad = 0;
      for (int i = 0; i < 4; i++) begin
        if (mon_b[i] !== sent[i]) bad++;
        rd(1, v);
        if (v[7:0] !== (sent[i] ^ {8{inv_b}})) bad++;
      end
      chk("R4 msb-first stream and capture", bad, 0);
    end
    inv_b = 1'b0; cpol_b = 1'b0; cpha_b = 1'b0;
    rd(1, v); chk("R7 empty read", v, 0);

    // R5 select levels
    wr(0, mkctl(0, 0, 0, 0, 1, 0, 0, 0, 0, 3'b010) | 32'h30);
    @(negedge clk); chk("R5 line0 low, line1 inverted idle", spi_cs, 3'b100);
    wr(0, mkctl(2, 0, 0, 1, 1, 0, 0, 0, 0, 3'b000));
    @(negedge clk); chk("R5 global high level", spi_cs, 3'b100);
    wr(0, mkctl(3, 0, 0, 0, 1, 0, 0, 0, 0, 3'b000));
    @(negedge clk); chk("R5 no line", spi_cs, 3'b111);

    // R7 transmit clear: queued bytes never go out
    wr(0, 32'h30);
    for (int i = 0; i < 5; i++) wr(1, 8'h3C);
    wr(0, 32'h10);
    mclear();
    wr(0, mkctl(3, 0, 0, 0, 1, 0, 0, 0, 0, 3'b000));
    repeat (40) @(negedge clk);
    chk("R7 tx clear no toggles", toggles, 0);
    rd(0, v); chk("R7 tx clear done", v[16], 1'b1);

    // R6 full queues, stall, R11 receive interrupt, R7 rx clear
    wr(2, 2);
    wr(0, 32'h30);
    for (int i = 0; i < 16; i++) begin sent[i] = 8'($urandom); wr(1, sent[i]); end
    rd(0, v); chk("R6 tx full no space", v[18], 1'b0);
    wr(0, mkctl(0, 0, 0, 0, 1, 0, 0, 1, 0, 3'b000));
    wait_stat(20, 400);
    rd(0, v); chk("R6 rx full and level", {v[20], v[19], v[17]}, 3'b111);
    chk("R11 rx level interrupt", irq, 1'b1);
    mclear();
    sent[16] = 8'h5A; wr(1, sent[16]);
    repeat (60) @(negedge clk);
    chk("R6 stall while rx full", toggles, 0);
    bad = 0;
    rd(1, v); if (v[7:0] !== sent[0]) bad++;
    wait_stat(16, 400);
    for (int i = 1; i < 17; i++) begin rd(1, v); if (v[7:0] !== sent[i]) bad++; end
    chk("R6 order after stall", bad, 0);
    chk("R11 level gone", irq, 1'b0);
    wr(1, 8'h11); wait_stat(16, 200);
    rd(0, v); chk("R7 rx before clear", v[17], 1'b1);
    wr(0, 32'h20);
    rd(0, v); chk("R7 rx cleared", v[17], 1'b0);

    // R8 / R10 / R11 automatic release with DMA pacing
    wr(3, 3);
    mclear();
    wr(0, mkctl(1, 0, 0, 0, 1, 1, 1, 0, 1, 3'b000));
    chk("R10 tx request on start", {dma_tx_req, dma_rx_req, irq}, 3'b100);
    for (int i = 0; i < 3; i++) wr(1, 8'h81 + i);
    chk("R10 tx request after count", dma_tx_req, 1'b0);
    for (int i = 0; i < 400; i++) begin rd(0, v); if (!v[7]) break; end
    rd(0, v);
    chk("R8 run cleared and done", {v[7], v[16]}, 2'b01);
    chk("R8 select released", spi_cs, 3'b111);
    chk("R8 bytes exchanged", toggles, 48);
    chk("R11 done interrupt", irq, 1'b1);
    chk("R10 rx request", dma_rx_req, 1'b1);
    wr(0, mkctl(1, 0, 0, 0, 0, 1, 1, 0, 1, 3'b000));
    rd(0, v); chk("R8 done cleared by write", v[16], 1'b0);
    chk("R11 interrupt cleared", irq, 1'b0);
    bad = 0;
    for (int i = 0; i < 3; i++) begin rd(1, v); if (v[7:0] !== 8'(8'h81 + i)) bad++; end
    chk("R8 received bytes", bad, 0);
    chk("R10 rx request drained", dma_rx_req, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule